// File: doc/BRIEF.md
# Cycle-Qualified Address Decoder

This block is the glue between a 24-bit-address CPU that reports the kind of each bus cycle on two status pins and the memories and peripherals behind it. One pin, here `vda`, marks cycles whose address is a valid data address. The other, `vpa`, marks cycles whose address is a valid program address. Both high means an opcode fetch, and both low means an internal cycle whose address is incidental. The decoder turns the address into active-low chip selects for ROM, RAM and eight I/O devices. Each select is gated by the cycle type. Peripherals whose registers change state when read, such as interrupt flags that clear on a read, are therefore never touched by an incidental cycle.

Memory that may hold code accepts both data and program cycles. The I/O devices accept only data cycles. An opcode fetch aimed at the I/O window reaches no device and reads as $00. An optional guard watches the data bus during opcode fetches. When it sees an opcode on its ban list (by default the stop and wait-for-interrupt opcodes), it hands the CPU a NOP ($EA) instead. It also raises a one-cycle pulse and a sticky flag.

Top module: `cyc_qual_decoder`

## Requirements
- R1: The address map is fixed by parameters. Addresses 0x00DE00 to 0x00DEFF form the I/O window. Addresses 0x008000 to 0x00FFFF outside that window are ROM. Every other address is RAM, including the window's offsets in other banks.
- R2: `rom_cs_n` and `ram_cs_n` go low for their region only when `vda` or `vpa` is high, for reads and for writes.
- R3: `io_cs_n[k]` goes low only when `vda`=1 and `vpa`=0 and the address is in the I/O window. k is address bits [7:5], so each device owns 32 bytes.
- R4: A read with `vda`=`vpa`=1 in the I/O window asserts no select. It drives `cpu_data_out`=0x00 with `data_ovr`=1.
- R5: On an internal cycle (`vda`=`vpa`=0), no select is asserted and `data_ovr` is 0.
- R6: At most one select is low at any time. While `rst_n` is low, every select is high.
- R7: The selects and the I/O-fetch override follow the inputs within the same cycle, with no clock edge in the path.
- R8: With `guard_en`=1, a read with `vda`=`vpa`=1 outside the I/O window whose `cpu_data_in` is 0xDB or 0xCB drives `cpu_data_out`=0xEA with `data_ovr`=1.
- R9: A guarded hit sets `viol_pulse` high for exactly the one cycle after the clock edge that ends the fetch. The same edge sets `viol_flag`, which stays high until `viol_clr` is sampled high at a clock edge or until reset.
- R10: In every case not covered by R4 or R8 (guard off, other opcodes, data cycles, writes), `cpu_data_out` equals `cpu_data_in` and `data_ovr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the guard's registers |
| rst_n | input | 1 | Active-low reset; forces all selects high |
| addr | input | 24 | CPU address |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Cycle carries a valid data address |
| vpa | input | 1 | Cycle carries a valid program address |
| cpu_data_in | input | 8 | Data returned by the addressed device |
| guard_en | input | 1 | Enables the opcode guard |
| viol_clr | input | 1 | Clears the sticky violation flag |
| cpu_data_out | output | 8 | Data presented to the CPU |
| data_ovr | output | 1 | High when the block substitutes the read data |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| io_cs_n | output | 8 | I/O device selects, active low |
| viol_pulse | output | 1 | One-cycle pulse after a banned fetch |
| viol_flag | output | 1 | Sticky banned-fetch flag |

## Verification
A wrong region boundary or a wrong qualification term shows up at once as a select that is low in the wrong cycle type. It can also show up as a select that stays high when it should be low, on the same vector and before any clock edge. Sweeping every bank-0 page against all four cycle types and both directions exposes it. A faulty ban-list match shows up in `cpu_data_out` in the fetch cycle itself. A faulty flag or pulse register shows up one edge later, so the full 256-opcode sweep checks both points for each opcode.

// File: rtl/cqd_pkg.sv
package cqd_pkg;

  typedef enum logic [1:0] {
    RG_RAM = 2'd0,
    RG_ROM = 2'd1,
    RG_IO  = 2'd2
  } region_t;

  localparam logic [7:0] OP_NOP  = 8'hEA;
  localparam logic [7:0] IO_FILL = 8'h00;

  // Cycle-type helpers, kept as functions so the bench can restate them.
  function automatic logic is_fetch(input logic vda, input logic vpa);
    return vda & vpa;
  endfunction

  function automatic logic mem_ok(input logic vda, input logic vpa);
    return vda | vpa;
  endfunction

  function automatic logic io_ok(input logic vda, input logic vpa);
    return vda & ~vpa;
  endfunction

endpackage

// File: rtl/cqd_region.sv
module cqd_region
  import cqd_pkg::*;
#(
  parameter int AW = 24,
  parameter int IO_DEVS = 8,
  parameter int DEV_BYTES = 32,
  parameter logic [AW-1:0] IO_BASE = 24'h00DE00,
  parameter logic [AW-1:0] ROM_LO = 24'h008000,
  parameter logic [AW-1:0] ROM_HI = 24'h00FFFF
) (
  input  logic [AW-1:0]              addr,
  output region_t                    region,
  output logic [$clog2(IO_DEVS)-1:0] io_idx
);
  localparam int IDX_W  = $clog2(IO_DEVS);
  localparam int DEV_SH = $clog2(DEV_BYTES);
  localparam int WIN_SH = IDX_W + DEV_SH;

  logic in_io;
  logic in_rom;

  assign in_io  = (addr[AW-1:WIN_SH] == IO_BASE[AW-1:WIN_SH]);
  assign in_rom = (addr >= ROM_LO) && (addr <= ROM_HI);
  assign io_idx = addr[WIN_SH-1:DEV_SH];

  always_comb begin
    if (in_io)       region = RG_IO;
    else if (in_rom) region = RG_ROM;
    else             region = RG_RAM;
  end
endmodule

// File: rtl/cqd_select.sv
module cqd_select
  import cqd_pkg::*;
#(
  parameter int IO_DEVS = 8
) (
  input  logic                       rst_n,
  input  region_t                    region,
  input  logic [$clog2(IO_DEVS)-1:0] io_idx,
  input  logic                       vda,
  input  logic                       vpa,
  input  logic                       rw,
  output logic                       rom_cs_n,
  output logic                       ram_cs_n,
  output logic [IO_DEVS-1:0]         io_cs_n,
  output logic                       io_fetch
);
  logic mem_q;
  logic io_q;

  assign mem_q    = rst_n & mem_ok(vda, vpa);
  assign io_q     = rst_n & io_ok(vda, vpa) & (region == RG_IO);
  assign rom_cs_n = ~(mem_q & (region == RG_ROM));
  assign ram_cs_n = ~(mem_q & (region == RG_RAM));
  assign io_fetch = rst_n & rw & is_fetch(vda, vpa) & (region == RG_IO);

  for (genvar k = 0; k < IO_DEVS; k++) begin : g_io
    assign io_cs_n[k] = ~(io_q & (io_idx == k[$clog2(IO_DEVS)-1:0]));
  end
endmodule

// File: rtl/cqd_guard.sv
module cqd_guard #(
  parameter int N_BAN = 2,
  parameter logic [N_BAN*8-1:0] BAN_OPS = {8'hDB, 8'hCB}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       guard_en,
  input  logic       fetch_mem,
  input  logic [7:0] opcode,
  input  logic       viol_clr,
  output logic       hit,
  output logic       viol_pulse,
  output logic       viol_flag
);
  function automatic logic banned(input logic [7:0] op);
    logic m;
    m = 1'b0;
    for (int i = 0; i < N_BAN; i++) begin
      if (BAN_OPS[i*8 +: 8] == op) m = 1'b1;
    end
    return m;
  endfunction

  assign hit = guard_en & fetch_mem & banned(opcode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pulse <= 1'b0;
      viol_flag  <= 1'b0;
    end else begin
      viol_pulse <= hit;
      if (hit)           viol_flag <= 1'b1;
      else if (viol_clr) viol_flag <= 1'b0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> (!viol_pulse || $past(hit))); // R9
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag); // R9
endmodule

// File: rtl/cyc_qual_decoder.sv
module cyc_qual_decoder
  import cqd_pkg::*;
#(
  parameter int AW = 24,
  parameter int IO_DEVS = 8,
  parameter int DEV_BYTES = 32,
  parameter logic [AW-1:0] IO_BASE = 24'h00DE00,
  parameter logic [AW-1:0] ROM_LO = 24'h008000,
  parameter logic [AW-1:0] ROM_HI = 24'h00FFFF,
  parameter int N_BAN = 2,
  parameter logic [N_BAN*8-1:0] BAN_OPS = {8'hDB, 8'hCB}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               rw,
  input  logic               vda,
  input  logic               vpa,
  input  logic [7:0]         cpu_data_in,
  input  logic               guard_en,
  input  logic               viol_clr,
  output logic [7:0]         cpu_data_out,
  output logic               data_ovr,
  output logic               rom_cs_n,
  output logic               ram_cs_n,
  output logic [IO_DEVS-1:0] io_cs_n,
  output logic               viol_pulse,
  output logic               viol_flag
);
  localparam int IDX_W = $clog2(IO_DEVS);

  region_t    region;
  logic [IDX_W-1:0] io_idx;
  logic       io_fetch;
  logic       fetch_mem;
  logic       guard_hit;

  cqd_region #(
    .AW(AW), .IO_DEVS(IO_DEVS), .DEV_BYTES(DEV_BYTES),
    .IO_BASE(IO_BASE), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
  ) u_region (
    .addr(addr), .region(region), .io_idx(io_idx)
  );

  cqd_select #(.IO_DEVS(IO_DEVS)) u_select (
    .rst_n(rst_n), .region(region), .io_idx(io_idx),
    .vda(vda), .vpa(vpa), .rw(rw),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .io_cs_n(io_cs_n), .io_fetch(io_fetch)
  );

  assign fetch_mem = rst_n & rw & is_fetch(vda, vpa) & (region != RG_IO);

  cqd_guard #(.N_BAN(N_BAN), .BAN_OPS(BAN_OPS)) u_guard (
    .clk(clk), .rst_n(rst_n), .guard_en(guard_en),
    .fetch_mem(fetch_mem), .opcode(cpu_data_in), .viol_clr(viol_clr),
    .hit(guard_hit), .viol_pulse(viol_pulse), .viol_flag(viol_flag)
  );

  always_comb begin
    data_ovr     = 1'b0;
    cpu_data_out = cpu_data_in;
    if (io_fetch) begin
      data_ovr     = 1'b1;
      cpu_data_out = IO_FILL;
    end else if (guard_hit) begin
      data_ovr     = 1'b1;
      cpu_data_out = OP_NOP;
    end
  end

  AST_IO_NEEDS_DATA_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cs_n != '1) |-> (vda && !vpa)); // R3
  AST_SELECTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rom_cs_n, ~ram_cs_n, ~io_cs_n})); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!vda && !vpa) |-> (rom_cs_n && ram_cs_n && (io_cs_n == '1) && !data_ovr)); // R5
  AST_IO_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    io_fetch |-> (data_ovr && cpu_data_out == 8'h00 && io_cs_n == '1)); // R4
  AST_MEM_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n || !ram_cs_n) |-> (vda || vpa)); // R2
endmodule

// File: tb/cyc_qual_decoder_tb.sv
module cyc_qual_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        rw = 1'b1, vda = 1'b0, vpa = 1'b0;
  logic [7:0]  din = '0;
  logic        guard_en = 1'b0, viol_clr = 1'b0;
  logic [7:0]  dout;
  logic        ovr, rom_n, ram_n, vpulse, vflag;
  logic [7:0]  io_n;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cyc_qual_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .vda(vda), .vpa(vpa),
    .cpu_data_in(din), .guard_en(guard_en), .viol_clr(viol_clr),
    .cpu_data_out(dout), .data_ovr(ovr), .rom_cs_n(rom_n), .ram_cs_n(ram_n),
    .io_cs_n(io_n), .viol_pulse(vpulse), .viol_flag(vflag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Region per R1: 2 = io, 1 = rom, 0 = ram
  function automatic int region_of(input logic [23:0] a);
    if (a[23:8] == 16'h00DE) return 2;
    if (a >= 24'h008000 && a <= 24'h00FFFF) return 1;
    return 0;
  endfunction

  // Expected {rom_n, ram_n, io_n[7:0]}
  function automatic logic [9:0] exp_sel(input logic [23:0] a, input logic d, input logic p);
    logic [9:0] s;
    int r;
    s = '1;
    r = region_of(a);
    if (r == 1 && (d || p)) s[9] = 1'b0;
    if (r == 0 && (d || p)) s[8] = 1'b0;
    if (r == 2 && d && !p) s[a[7:5]] = 1'b0;
    return s;
  endfunction

  task automatic apply_vec(input logic [23:0] a, input logic d, input logic p, input logic w, input logic [7:0] b);
    logic [9:0] es;
    logic       eo;
    logic [7:0] ed;
    addr = a; vda = d; vpa = p; rw = w; din = b;
    #2;
    es = exp_sel(a, d, p);
    eo = (region_of(a) == 2) && d && p && w;
    ed = eo ? 8'h00 : b;
    // R2 R3 R7: selects valid in the same cycle
    chk({rom_n, ram_n, io_n} == es, (region_of(a) == 2) ? "R3 io select" : "R2 mem select",
        {22'd0, rom_n, ram_n, io_n}, {22'd0, es});
    if (!d && !p) chk(!ovr && {rom_n, ram_n, io_n} == '1, "R5 idle cycle", {31'd0, ovr}, 0);
    else if (eo) chk(ovr && dout == 8'h00, "R4 io fetch", {23'd0, ovr, dout}, {23'd0, 1'b1, 8'h00});
    else chk(!ovr && dout == ed, "R10 passthrough", {23'd0, ovr, dout}, {23'd0, 1'b0, ed});
    chk($countones(~{rom_n, ram_n, io_n}) <= 1, "R6 exclusive", {22'd0, rom_n, ram_n, io_n}, 0);
  endtask

  initial begin : watchdog
    #3000000;
    if (!done) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : stim
    logic [23:0] a;
    logic        hb;
    logic        ef;
    // R6: reset holds every select high even on a qualifying cycle
    addr = 24'h000100; vda = 1; vpa = 0;
    #5;
    chk(rom_n && ram_n && io_n == 8'hFF, "R6 reset selects", {22'd0, rom_n, ram_n, io_n}, 32'h3FF);
    addr = 24'h00DE20;
    #1;
    chk(io_n == 8'hFF, "R6 reset io", {24'd0, io_n}, 32'hFF);
    chk(!vpulse && !vflag, "R9 reset flags", {30'd0, vpulse, vflag}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R10: sweep bank 0 pages x cycle types x direction
    for (int pg = 0; pg < 256; pg++) begin
      a = {8'h00, pg[7:0], pg[7:0] * 8'd37 + 8'd5};
      for (int c = 0; c < 8; c++) begin
        apply_vec(a, c[0], c[1], c[2], pg[7:0] ^ 8'h5A);
      end
    end
    // R3: every I/O device slot boundary in the window
    for (int k = 0; k < 8; k++) begin
      apply_vec({16'h00DE, k[2:0], 5'd0}, 1, 0, 1, 8'h11);
      apply_vec({16'h00DE, k[2:0], 5'd31}, 1, 0, 0, 8'h22);
    end
    // R1: edges of the map and other banks
    apply_vec(24'h007FFF, 1, 0, 1, 8'h33);
    apply_vec(24'h008000, 1, 0, 1, 8'h34);
    apply_vec(24'h00DDFF, 0, 1, 1, 8'h35);
    apply_vec(24'h00DF00, 1, 1, 1, 8'h36);
    apply_vec(24'h00FFFF, 1, 1, 1, 8'h37);
    apply_vec(24'h010000, 1, 0, 1, 8'h38);
    apply_vec(24'h01DE40, 1, 0, 1, 8'h39);
    apply_vec(24'h7F8000, 0, 1, 1, 8'h3A);
    apply_vec(24'hFFFFFF, 1, 1, 1, 8'h3B);
    apply_vec(24'h00DE40, 1, 1, 0, 8'h3C);

    // R8 R9 R10: guard sweep over all opcodes, guard on and off
    for (int g = 0; g < 2; g++) begin
      guard_en = g[0];
      for (int op = 0; op < 256; op++) begin
        @(negedge clk);
        viol_clr = 1'b1;
        addr = 24'h00C000 + op; vda = 1; vpa = 1; rw = 1; din = op[7:0];
        #2;
        hb = (op == 8'hDB) || (op == 8'hCB);
        ef = g[0] && hb;
        if (ef) chk(ovr && dout == 8'hEA, "R8 banned opcode nop", {23'd0, ovr, dout}, 32'h1EA);
        else chk(!ovr && dout == op[7:0], "R10 opcode passthrough", {23'd0, ovr, dout}, {24'd0, op[7:0]});
        @(negedge clk);
        viol_clr = 1'b0;
        vda = 0; vpa = 0;
        chk(vpulse == ef && vflag == ef, "R9 pulse and flag", {30'd0, vpulse, vflag}, {30'd0, ef, ef});
        @(negedge clk);
        chk(!vpulse && vflag == ef, "R9 one-cycle pulse, sticky flag", {30'd0, vpulse, vflag}, {30'd0, 1'b0, ef});
      end
    end
    // R8 R10: banned opcode as data cycle, as write, and at I/O window
    guard_en = 1;
    apply_vec(24'h00C100, 1, 0, 1, 8'hDB);
    apply_vec(24'h00C100, 0, 1, 0, 8'hDB);
    apply_vec(24'h00DE00, 1, 1, 1, 8'hDB);
    // R9: flag holds until clear
    @(negedge clk);
    addr = 24'h000200; vda = 1; vpa = 1; rw = 1; din = 8'hCB;
    @(negedge clk);
    vda = 0; vpa = 0;
    repeat (3) @(negedge clk);
    chk(vflag && !vpulse, "R9 flag held", {30'd0, vpulse, vflag}, 32'h1);
    viol_clr = 1;
    @(negedge clk);
    viol_clr = 0;
    chk(!vflag, "R9 flag cleared", {31'd0, vflag}, 0);
    // R9: reset clears flag
    addr = 24'h000200; vda = 1; vpa = 1; din = 8'hDB;
    @(negedge clk);
    vda = 0; vpa = 0;
    rst_n = 0;
    #2;
    chk(!vflag && !vpulse, "R9 reset clears flag", {30'd0, vpulse, vflag}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule